// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock (48 MHz in the intended system) into a one-cycle tick at sixteen times a UART's baud rate. The divisor has a 14-bit integer part and a 3-bit fraction counted in eighths. A divisor of n + f/8 is made by running periods of n reference cycles and adding one extra cycle to exactly f of every eight tick periods. The extra cycles are spread across the group of eight so that the tick jitters by at most one reference clock. Over a group of eight periods the total length is 8n + f cycles.

A divisor is presented on the two field inputs and captured by a one-cycle load strobe. After reset the block is idle and the tick stays low until the first load. That first load starts counting at once. A load that arrives while ticks are already running is held. It takes over only when the current period ends, so no period is ever cut short. Two small integer values are reserved for the fastest rates. An integer of 0 gives a tick on every cycle. An integer of 1 gives an alternating 1,2 pattern, which averages 1.5 cycles. There is no data stream, so all pins are plain control and status pins with no handshake.

Top module: `brg_tick_gen`

## Requirements
- R1: While running, `tick` is high for single cycles spaced P cycles apart, where P is n plus 0 or 1 extra cycle, n is the applied integer field (2..16383) and the extra cycle comes from the fraction rule in R3.
- R2: During reset and after it, `tick` stays low until the first cycle in which `load` is sampled high.
- R3: Number the periods k = 0,1,2,... starting from the first period that uses a newly applied divisor, and take k modulo 8. Period k is lengthened by one cycle exactly when floor((k+1)*f/8) > floor(k*f/8). Period 0 is therefore never lengthened, and each group of eight periods contains exactly f lengthened ones.
- R4: An integer field of 0 gives a tick in every cycle, whatever the fraction field holds.
- R5: An integer field of 1 behaves as a fraction of 4/8 with a base of one cycle, so the periods run 1,2,1,2,..., starting with 1. The fraction field is ignored.
- R6: A load that arrives while ticks are running lets the current period finish with the old divisor. The new divisor's pattern starts with period 0 immediately after the next tick. A load sampled in a tick cycle applies to the period that begins right after that tick.
- R7: A load taken while idle starts period 0 at once. The first tick appears in the P0-th cycle after the edge that samples the load.
- R8: Changing `div_int` or `div_frac` without `load` has no effect on the tick spacing.
- R9: The largest divisor works. With n = 16383 and f = 7 the periods run 16383 followed by 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_int | input | 14 | Integer part of the divisor |
| div_frac | input | 3 | Fractional part of the divisor, in eighths |
| load | input | 1 | One-cycle strobe that captures both divisor fields |
| tick | output | 1 | One-cycle oversampling tick |

## Verification
The assertions rely on three assumptions. First, `load` is a clean synchronous strobe. Second, the divisor fields are stable in any cycle where `load` is high. Third, no load is issued so often that the gap between ticks could grow past the largest legal period. The bench changes inputs only away from the sampling edge, holding them for a full cycle around each load. It raises `load` for exactly one cycle at a time. It issues a reload while running only in the middle of a period, or in the tick cycle itself, and in both cases one full period passes before the next load.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int BRG_INT_W  = 14;
  localparam int BRG_FRAC_W = 3;

  typedef enum logic [1:0] {
    DIV_UNITY,
    DIV_HALF,
    DIV_FRAC
  } div_mode_e;
endpackage

// File: rtl/brg_divisor_latch.sv
module brg_divisor_latch
  import brg_pkg::*;
#(
  parameter int INT_W  = BRG_INT_W,
  parameter int FRAC_W = BRG_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  n_in,
  input  logic [FRAC_W-1:0] f_in,
  input  logic              boundary,
  output logic              active,
  output logic              pend,
  output logic              fresh,
  output logic [INT_W-1:0]  sel_n,
  output logic [FRAC_W-1:0] sel_f,
  output logic [INT_W-1:0]  cur_n
);
  logic [INT_W-1:0]  sh_n;
  logic [FRAC_W-1:0] sh_f;
  logic [FRAC_W-1:0] cur_f;

  // A divisor that arrives in the same cycle as a boundary is used directly.
  always_comb begin
    fresh = load | pend;
    if (load) begin
      sel_n = n_in;
      sel_f = f_in;
    end else if (pend) begin
      sel_n = sh_n;
      sel_f = sh_f;
    end else begin
      sel_n = cur_n;
      sel_f = cur_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= 1'b0;
      sh_n   <= '0;
      sh_f   <= '0;
      cur_n  <= '0;
      cur_f  <= '0;
    end else begin
      if (load) active <= 1'b1;
      if (load && !boundary) begin
        sh_n <= n_in;
        sh_f <= f_in;
        pend <= 1'b1;
      end else if (boundary) begin
        pend <= 1'b0;
      end
      if (boundary) begin
        cur_n <= sel_n;
        cur_f <= sel_f;
      end
    end
  end
endmodule

// File: rtl/brg_frac_spreader.sv
module brg_frac_spreader
  import brg_pkg::*;
#(
  parameter int INT_W  = BRG_INT_W,
  parameter int FRAC_W = BRG_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              fresh,
  input  logic [INT_W-1:0]  n,
  input  logic [FRAC_W-1:0] f,
  output logic [INT_W:0]    period
);
  localparam logic [FRAC_W-1:0] HALF_F = {1'b1, {(FRAC_W-1){1'b0}}};

  div_mode_e         mode;
  logic [INT_W-1:0]  n_eff;
  logic [FRAC_W-1:0] f_eff;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] base;
  logic [FRAC_W:0]   sum;

  always_comb begin
    if (n == '0)                  mode = DIV_UNITY;
    else if (n == INT_W'(1))      mode = DIV_HALF;
    else                          mode = DIV_FRAC;
  end

  always_comb begin
    unique case (mode)
      DIV_UNITY: begin n_eff = INT_W'(1); f_eff = '0;     end
      DIV_HALF:  begin n_eff = INT_W'(1); f_eff = HALF_F; end
      default:   begin n_eff = n;         f_eff = f;      end
    endcase
  end

  // The carry out of the phase accumulator marks a lengthened period.
  always_comb begin
    base   = fresh ? '0 : acc_q;
    sum    = {1'b0, base} + {1'b0, f_eff};
    period = {1'b0, n_eff} + (INT_W+1)'(sum[FRAC_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (boundary) acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/brg_period_counter.sv
module brg_period_counter
  import brg_pkg::*;
#(
  parameter int INT_W = BRG_INT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           start,
  input  logic [INT_W:0] period,
  output logic           tick,
  output logic           boundary,
  output logic [INT_W:0] cnt
);
  always_comb begin
    tick     = active && (cnt == '0);
    boundary = tick || start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (boundary) cnt <= period - (INT_W+1)'(1);
    else if (active)   cnt <= cnt - (INT_W+1)'(1);
  end
endmodule

// File: rtl/brg_tick_gen.sv
module brg_tick_gen
  import brg_pkg::*;
#(
  parameter int INT_W  = BRG_INT_W,
  parameter int FRAC_W = BRG_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              load,
  output logic              tick
);
  logic              active;
  logic              pend;
  logic              fresh;
  logic              boundary;
  logic              start;
  logic [INT_W-1:0]  sel_n;
  logic [FRAC_W-1:0] sel_f;
  logic [INT_W-1:0]  cur_n;
  logic [INT_W:0]    period;
  logic [INT_W:0]    cnt;

  assign start = load && !active;

  brg_divisor_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .n_in(div_int), .f_in(div_frac),
    .boundary(boundary), .active(active), .pend(pend), .fresh(fresh),
    .sel_n(sel_n), .sel_f(sel_f), .cur_n(cur_n)
  );

  brg_frac_spreader #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_spread (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .fresh(fresh),
    .n(sel_n), .f(sel_f), .period(period)
  );

  brg_period_counter #(.INT_W(INT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .active(active), .start(start),
    .period(period), .tick(tick), .boundary(boundary), .cnt(cnt)
  );
endmodule

// File: rtl/brg_tick_checker.sv
module brg_tick_checker #(
  parameter int INT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             tick,
  input logic             active,
  input logic             pend,
  input logic [INT_W-1:0] cur_n,
  input logic [INT_W:0]   cnt
);
  localparam logic [INT_W+1:0] MAXP = (INT_W+2)'(1) << INT_W;

  logic             seen_load;
  logic [INT_W+1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_load <= 1'b0;
      gap       <= '0;
    end else begin
      if (load) seen_load <= 1'b1;
      if (tick || (load && !seen_load)) gap <= (INT_W+2)'(1);
      else if (gap != '1)               gap <= gap + (INT_W+2)'(1);
    end
  end

  assert_quiet_until_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load |-> !tick);

  assert_period_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_load) |-> (gap <= MAXP));

  assert_unity_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && !load && cur_n == '0) |=> tick);

  assert_pending_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> !pend);

  assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(pend));

  assert_countdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !load) |=> (cnt == $past(cnt) - (INT_W+1)'(1)));
endmodule

bind brg_tick_gen brg_tick_checker #(.INT_W(INT_W)) u_tick_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .tick(tick),
  .active(active), .pend(pend), .cur_n(cur_n), .cnt(cnt)
);

// File: tb/test_brg_tick_gen.sv
module test_brg_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] div_int = '0;
  logic [2:0]  div_frac = '0;
  logic        load = 1'b0;
  logic        tick;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  brg_tick_gen i_brg_tick_gen (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
    .load(load), .tick(tick)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<=190000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int n, input int f, input int k);
    int ne = (n == 0) ? 1 : n;
    int fe = (n == 0) ? 0 : ((n == 1) ? 4 : f);
    int kk = k % 8;
    return ne + ((((kk + 1) * fe) / 8 > (kk * fe) / 8) ? 1 : 0);
  endfunction

  task automatic count_to_tick(inout int c);
    while (!tick && c < 20000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic next_interval(output int c);
    @(negedge clk);
    c = 1;
    count_to_tick(c);
  endtask

  task automatic do_reset();
    int hi = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (tick) hi++;
    end
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (tick) hi++;
    end
    chk(hi == 0, "R2 tick low before load", hi, 0);
  endtask

  // Issue a load from the current negedge; returns after the sampling edge.
  task automatic pulse_load(input int n, input int f);
    div_int  = 14'(n);
    div_frac = 3'(f);
    load     = 1'b1;
    @(posedge clk);
    #1 load = 1'b0;
  endtask

  task automatic run_fresh(input int n, input int f, input int nper, input string req);
    int c;
    do_reset();
    @(negedge clk);
    pulse_load(n, f);
    @(negedge clk);
    c = 1;
    count_to_tick(c);
    chk(c == exp_period(n, f, 0), {req, " R7 first period"}, c, exp_period(n, f, 0));
    for (int k = 1; k < nper; k++) begin
      next_interval(c);
      chk(c == exp_period(n, f, k), req, c, exp_period(n, f, k));
    end
  endtask

  initial begin
    int c;
    int total;
    void'($urandom(32'd2024));

    do_reset();

    // R1/R3: directed fractions over two full groups
    run_fresh(5, 0, 8, "R1 integer only");
    run_fresh(6, 3, 16, "R3 fraction 3/8");
    run_fresh(2, 7, 16, "R3 fraction 7/8 at n=2");
    run_fresh(9, 4, 8, "R3 fraction 4/8");
    run_fresh(0, 7, 10, "R4 unity ignores fraction");
    run_fresh(1, 2, 10, "R5 half rate ignores fraction");

    // R3: group total is 8n+f
    do_reset();
    @(negedge clk);
    pulse_load(11, 5);
    @(negedge clk);
    c = 1;
    count_to_tick(c);
    total = c;
    for (int k = 1; k < 8; k++) begin
      next_interval(c);
      total += c;
    end
    chk(total == 8 * 11 + 5, "R3 group total", total, 8 * 11 + 5);

    // R8: field changes without load
    div_int  = 14'd3;
    div_frac = 3'd1;
    for (int k = 8; k < 16; k++) begin
      next_interval(c);
      chk(c == exp_period(11, 5, k), "R8 fields ignored without load", c, exp_period(11, 5, k));
    end

    // R6: reload in mid period
    run_fresh(7, 3, 3, "R6 setup");
    @(negedge clk);
    @(negedge clk);
    pulse_load(10, 6);
    @(negedge clk);
    c = 3;
    count_to_tick(c);
    chk(c == exp_period(7, 3, 3), "R6 old period completes", c, exp_period(7, 3, 3));
    for (int k = 0; k < 8; k++) begin
      next_interval(c);
      chk(c == exp_period(10, 6, k), "R6 new pattern restarts", c, exp_period(10, 6, k));
    end

    // R6: reload sampled in the tick cycle
    pulse_load(4, 5);
    for (int k = 0; k < 8; k++) begin
      if (k == 0) begin
        @(negedge clk);
        c = 1;
        count_to_tick(c);
      end else begin
        next_interval(c);
      end
      chk(c == exp_period(4, 5, k), "R6 load in tick cycle", c, exp_period(4, 5, k));
    end

    // R9: largest divisor
    run_fresh(16383, 7, 2, "R9 largest divisor");

    // R1/R3: constrained random divisors
    for (int i = 0; i < 16; i++) begin
      int n = 2 + int'($urandom_range(38));
      int f = int'($urandom_range(7));
      run_fresh(n, f, 9, "R1 random divisor");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule